// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block gathers level-sensitive device interrupt lines and hands exactly one of them at a time to the processor. Two kinds of source feed it. The first is up to 64 direct vector lines, each already carrying its vector number. The second is 16 legacy bus lines, which reach a vector number through a fixed, sparse translation. Once a line is captured, the unit sets its busy flag. It packs the vector into the first of three 64-bit dispatch data words, presents the vector-interrupt trap code and raises its interrupt request. It also gives a one-cycle wake pulse that releases a halted processor.

While busy, the dispatch words are frozen and new requests wait. The entry frees itself in one of two ways: the captured line drops, or software pulses the clear input. In the next cycle, any line that is still asserted competes again. When several lines are candidates, the lowest vector number wins.

Top module: `ivd_top`

## Requirements
- R1: After reset, status, all three data words, the trap code, the interrupt request and the wake pulse are all zero.
- R2: When the unit is idle and at least one line is asserted at a clock edge, busy (status bit 5, value 0x20) and `irq_o` are high after that edge.
- R3: On capture, data word 0 becomes 0x7C0 OR the vector number (the field 0x1F in bits 10:6, the vector in bits 5:0). Data words 1 and 2 read zero at all times.
- R4: `trap_o` reads 0x060 while busy and 0 while idle. `wake_o` is high for exactly the one cycle after the edge that captured a line.
- R5: A line asserted while busy is not captured and leaves data word 0 unchanged.
- R6: When the captured line is low at an edge while busy, busy and `irq_o` are low after that edge, and data word 0 keeps its value.
- R7: `sw_clr_i` high at an edge while busy clears busy and `irq_o` after that edge, even if the captured line is still high.
- R8: Legacy line 1 maps to vector 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. Every other legacy line has no effect, and a legacy table wider than 16 lines is a design error.
- R9: Among lines asserted together, the lowest vector number is captured. A line that loses stays a candidate and is captured once the unit is idle, provided it is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vec_irq_i | input | 64 | Direct vector lines, bit n is vector n |
| leg_irq_i | input | 16 | Legacy bus lines, translated to vectors |
| sw_clr_i | input | 1 | Software acknowledge, frees the entry |
| status_o | output | 8 | Status byte, bit 5 is busy |
| word0_o | output | 64 | Dispatch data word 0 (tag field and vector) |
| word1_o | output | 64 | Dispatch data word 1, always zero |
| word2_o | output | 64 | Dispatch data word 2, always zero |
| trap_o | output | 9 | Trap-type code, vector interrupt while busy |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | One-cycle halt-release pulse on capture |

## Verification
A release of the entry and a fresh request can fall in the same cycle. The bench provokes this by dropping the captured line while a second line is already high. It judges the result by requiring busy to be low after that edge, with word 0 still holding the old vector, and then by requiring the second vector to appear one edge later. The same pattern is driven with legacy lines, so the winner among several lines and the retry of the losers are seen through the translation. A software clear that arrives while the captured line is still high is checked alongside.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int IVD_WORD_W   = 64;
  localparam int IVD_LEG_MAX  = 16;
  localparam int IVD_BUSY_BIT = 5;
  localparam int IVD_TAG_LSB  = 6;
  localparam logic [4:0] IVD_TAG   = 5'h1F;
  localparam logic [8:0] IVD_TRAP  = 9'h060;

  typedef logic [IVD_WORD_W-1:0] ivd_word_t;

  // sparse legacy-line translation; -1 marks an unmapped line
  function automatic int leg_target(int line);
    case (line)
      1:       return 'h29;
      4:       return 'h2B;
      6:       return 'h27;
      7:       return 'h22;
      12:      return 'h2A;
      default: return -1;
    endcase
  endfunction

  function automatic ivd_word_t pack_word0(int unsigned vec);
    return (IVD_WORD_W'(IVD_TAG) << IVD_TAG_LSB) | IVD_WORD_W'(vec);
  endfunction
endpackage

// File: rtl/ivd_legacy_map.sv
module ivd_legacy_map #(
  parameter int NVEC = 64,
  parameter int NLEG = 16
) (
  input  logic [NVEC-1:0] vec_i,
  input  logic [NLEG-1:0] leg_i,
  output logic [NVEC-1:0] req_o
);
  localparam int IDX_W = $clog2(NVEC);

  always_comb begin
    req_o = vec_i;
    for (int l = 0; l < NLEG; l++) begin
      int t;
      t = ivd_pkg::leg_target(l);
      if (t >= 0 && t < NVEC && leg_i[l])
        req_o[t[IDX_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/ivd_prio_pick.sv
module ivd_prio_pick #(
  parameter int NVEC  = 64,
  parameter int IDX_W = $clog2(NVEC)
) (
  input  logic [NVEC-1:0]  req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/ivd_capture.sv
module ivd_capture #(
  parameter int IDX_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pick_valid_i,
  input  logic [IDX_W-1:0]    pick_idx_i,
  input  logic                line_hi_i,
  input  logic                sw_clr_i,
  output logic                busy_o,
  output logic [IDX_W-1:0]    vec_o,
  output ivd_pkg::ivd_word_t  word0_o,
  output logic                wake_o,
  output logic                take_o,
  output logic                drop_o
);
  assign take_o = !busy_o && pick_valid_i;
  assign drop_o = busy_o && (!line_hi_i || sw_clr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      vec_o   <= '0;
      word0_o <= '0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= take_o;
      if (take_o) begin
        busy_o  <= 1'b1;
        vec_o   <= pick_idx_i;
        word0_o <= ivd_pkg::pack_word0(32'(pick_idx_i));
      end else if (drop_o) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ivd_top.sv
module ivd_top #(
  parameter int NVEC = 64,
  parameter int NLEG = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NVEC-1:0]                vec_irq_i,
  input  logic [NLEG-1:0]                leg_irq_i,
  input  logic                           sw_clr_i,
  output logic [7:0]                     status_o,
  output logic [ivd_pkg::IVD_WORD_W-1:0] word0_o,
  output logic [ivd_pkg::IVD_WORD_W-1:0] word1_o,
  output logic [ivd_pkg::IVD_WORD_W-1:0] word2_o,
  output logic [8:0]                     trap_o,
  output logic                           irq_o,
  output logic                           wake_o
);
  localparam int IDX_W = $clog2(NVEC);

  logic [NVEC-1:0]  req_all;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] cap_vec;
  logic             cap_busy;
  logic             cap_line_hi;
  logic             cap_take;
  logic             cap_drop;

  ivd_legacy_map #(.NVEC(NVEC), .NLEG(NLEG)) map_i (
    .vec_i (vec_irq_i),
    .leg_i (leg_irq_i),
    .req_o (req_all)
  );

  ivd_prio_pick #(.NVEC(NVEC), .IDX_W(IDX_W)) pick_i (
    .req_i   (req_all),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign cap_line_hi = req_all[cap_vec];

  ivd_capture #(.IDX_W(IDX_W)) cap_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pick_valid_i (pick_valid),
    .pick_idx_i   (pick_idx),
    .line_hi_i    (cap_line_hi),
    .sw_clr_i     (sw_clr_i),
    .busy_o       (cap_busy),
    .vec_o        (cap_vec),
    .word0_o      (word0_o),
    .wake_o       (wake_o),
    .take_o       (cap_take),
    .drop_o       (cap_drop)
  );

  always_comb begin
    status_o = '0;
    status_o[ivd_pkg::IVD_BUSY_BIT] = cap_busy;
  end

  assign word1_o = '0;
  assign word2_o = '0;
  assign trap_o  = cap_busy ? ivd_pkg::IVD_TRAP : 9'h000;
  assign irq_o   = cap_busy;
endmodule

// File: rtl/ivd_chk.sv
module ivd_chk #(
  parameter int NVEC = 64,
  parameter int NLEG = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sw_clr_i,
  input logic [7:0]      status_o,
  input logic [63:0]     word0_o,
  input logic [63:0]     word1_o,
  input logic [63:0]     word2_o,
  input logic [8:0]      trap_o,
  input logic            wake_o,
  input logic [NVEC-1:0] req_all,
  input logic            cap_line_hi
);
  localparam int IDX_W = $clog2(NVEC);

  logic            busy;
  logic [NVEC-1:0] req_prev;
  logic [NVEC-1:0] low_mask;
  logic [IDX_W-1:0] cidx;

  assign busy = status_o[5];
  assign cidx = word0_o[IDX_W-1:0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) req_prev <= '0;
    else         req_prev <= req_all;
  end

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < NVEC; i++)
      if (IDX_W'(i) < cidx) low_mask[i] = 1'b1;
  end

  initial begin
    assert_leg_range_R8: assert (NLEG <= 16 && NVEC <= 64)
      else $error("legacy table or vector count out of range");
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && |req_all) |=> busy);

  assert_words_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word1_o == '0 && word2_o == '0));

  assert_tag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (word0_o[10:6] == 5'h1F));

  assert_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $rose(busy));

  assert_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy |-> trap_o == 9'h060) and (!busy |-> trap_o == 9'h000));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(word0_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !cap_line_hi) |=> !busy);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sw_clr_i) |=> !busy);

  assert_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (req_prev[cidx] && ((req_prev & low_mask) == '0)));
endmodule

bind ivd_top ivd_chk #(.NVEC(NVEC), .NLEG(NLEG)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_clr_i    (sw_clr_i),
  .status_o    (status_o),
  .word0_o     (word0_o),
  .word1_o     (word1_o),
  .word2_o     (word2_o),
  .trap_o      (trap_o),
  .wake_o      (wake_o),
  .req_all     (req_all),
  .cap_line_hi (cap_line_hi)
);

// File: tb/ivd_top_tb_top.sv
module ivd_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] vec_irq_i = '0;
  logic [15:0] leg_irq_i = '0;
  logic        sw_clr_i = 1'b0;
  logic [7:0]  status_o;
  logic [63:0] word0_o, word1_o, word2_o;
  logic [8:0]  trap_o;
  logic        irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  ivd_top dut_i (.*);

  // {vector lines, legacy lines, clear, expected busy, expected word0[11:0]}
  localparam int NSTEP = 20;
  localparam logic [93:0] STEPS [NSTEP] = '{
    {64'h20,               16'h0000, 1'b0, 1'b1, 12'h7C5}, // R2 R3 capture vec 5
    {64'h28,               16'h0000, 1'b0, 1'b1, 12'h7C5}, // R5 vec 3 while busy
    {64'h08,               16'h0000, 1'b0, 1'b0, 12'h7C5}, // R6 vec 5 drops, 3 waits
    {64'h08,               16'h0000, 1'b0, 1'b1, 12'h7C3}, // R9 retry of vec 3
    {64'h00,               16'h0000, 1'b0, 1'b0, 12'h7C3}, // R6
    {64'h00,               16'h0010, 1'b0, 1'b1, 12'h7EB}, // R8 line 4 -> 0x2B
    {64'h00,               16'h0000, 1'b0, 1'b0, 12'h7EB},
    {64'h00,               16'h8005, 1'b0, 1'b0, 12'h7EB}, // R8 lines 0,2,15 unmapped
    {64'h00,               16'h00C0, 1'b0, 1'b1, 12'h7E2}, // R9 lines 7,6: 0x22 wins
    {64'h00,               16'h0040, 1'b0, 1'b0, 12'h7E2}, // R6 0x22 drops
    {64'h00,               16'h0040, 1'b0, 1'b1, 12'h7E7}, // R8 line 6 -> 0x27
    {64'h00,               16'h0040, 1'b1, 1'b0, 12'h7E7}, // R7 clear with line high
    {64'h00,               16'h0000, 1'b0, 1'b0, 12'h7E7},
    {64'h8000000000000000, 16'h0000, 1'b0, 1'b1, 12'h7FF}, // R3 top vector 63
    {64'h8000020000000000, 16'h0002, 1'b0, 1'b1, 12'h7FF}, // R5 0x29 twice while busy
    {64'h00,               16'h0002, 1'b0, 1'b0, 12'h7FF}, // R6 release
    {64'h00,               16'h0002, 1'b0, 1'b1, 12'h7E9}, // R8 line 1 -> 0x29
    {64'h00,               16'h1000, 1'b0, 1'b0, 12'h7E9}, // R6
    {64'h00,               16'h1000, 1'b0, 1'b1, 12'h7EA}, // R8 line 12 -> 0x2A
    {64'h00,               16'h0000, 1'b0, 1'b0, 12'h7EA}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word0(input logic [5:0] v);
    return 64'd31 * 64'd64 + 64'(v);
  endfunction

  task automatic chk_idle_reset();
    chk("R1 status", 64'(status_o), 64'h0);
    chk("R1 word0", word0_o, 64'h0);
    chk("R1 word1", word1_o, 64'h0);
    chk("R1 word2", word2_o, 64'h0);
    chk("R1 trap", 64'(trap_o), 64'h0);
    chk("R1 irq", 64'(irq_o), 64'h0);
    chk("R1 wake", 64'(wake_o), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev_busy;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_idle_reset();

    prev_busy = 1'b0;
    for (int i = 0; i < NSTEP; i++) begin
      logic [93:0] s;
      logic        eb;
      s = STEPS[i];
      vec_irq_i = s[93:30];
      leg_irq_i = s[29:14];
      sw_clr_i  = s[13];
      eb        = s[12];
      @(negedge clk_i);
      chk("R2 busy", 64'(status_o), eb ? 64'h20 : 64'h0);
      chk("R2 irq", 64'(irq_o), 64'(eb));
      chk("R3 word0", word0_o, exp_word0(s[5:0]));
      chk("R3 word1/2", word1_o | word2_o, 64'h0);
      chk("R4 trap", 64'(trap_o), eb ? 64'h60 : 64'h0);
      chk("R4 wake", 64'(wake_o), 64'(eb && !prev_busy));
      prev_busy = eb;
    end

    // R5 and R9 directed: two lines together, low one captured, high one later
    vec_irq_i = 64'h0000_0000_0001_0004;
    leg_irq_i = '0;
    sw_clr_i  = 1'b0;
    @(negedge clk_i);
    chk("R9 lowest of 2,16", word0_o, exp_word0(6'd2));
    vec_irq_i = 64'h0000_0000_0001_0000;
    @(negedge clk_i);
    chk("R6 release with other line high", 64'(status_o), 64'h0);
    chk("R5 word0 kept", word0_o, exp_word0(6'd2));
    @(negedge clk_i);
    chk("R9 retry vec 16", word0_o, exp_word0(6'd16));

    // R1 reset while busy
    rst_ni = 1'b0;
    vec_irq_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk_idle_reset();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule